// File: doc/BRIEF.md
# Flash Program/Erase Flag Status Register

This block keeps the error and status flags that a serial NOR flash reports about its program and erase engine. A controller behind it signals when an operation starts, when it ends, whether it failed, whether the data pattern tried to turn a 0 back into a 1, what the high-voltage supply is doing, and whether a program is being suspended. The block turns these events into an 8-bit flag byte for the host. It also includes a clear command that returns the sticky error bits to zero.

The block also decides whether each new program or erase request is accepted. A request is accepted only when the engine is idle, no error flag is left over from before, and the target is not protected. Otherwise it is rejected at once. A rejection re-raises the error flag that belongs to the request, and the engine never goes busy.

The sequencing is a five-state machine. IDLE goes to PROG on an accepted program (transition *start_prog*) and to ERASE on an accepted erase (*start_erase*). PROG and ERASE return to IDLE on completion (*finish*). PROG goes to SUSP_WAIT on a suspend request (*suspend*). SUSP_WAIT goes to SUSP after `SUSP_LAT` cycles (*settle*), or back to IDLE if the operation completes first (*finish*). SUSP goes back to PROG on a resume request (*resume*).

Top module: `flash_flag_status`

## Requirements
- R1: After reset the flag byte is 8'h80: only the ready bit (bit 7) is 1, and the machine is in IDLE.
- R2: Bit 7 is 0 in PROG, ERASE and SUSP_WAIT, and 1 in IDLE and SUSP. Bits 6, 1 and 0 always read 0.
- R3: Bit 5 (erase error) sets in two cases: an erase finishes with `op_fail` high, or an erase request is rejected.
- R4: Bit 4 (program error) sets in two cases: a program finishes with `op_fail` high, or a program request is rejected (this includes a request with `cmd_protected` high).
- R5: During a program, `overwrite_try` sets bit 4 only when two conditions hold: the supply was valid when the operation started, and `pattern_bits` is a nonzero multiple of 64. In every other case it has no effect.
- R6: The supply level is sampled when an operation is accepted. Bit 3 sets when `supply_ok` is low during a running operation that started with a valid supply. An operation that started with the supply invalid never sets bit 3.
- R7: Bits 5, 4 and 3 are sticky and only `clear_flags` resets them. If a set event and `clear_flags` fall in the same cycle, the set event wins.
- R8: In IDLE, if any of bits 5, 4 or 3 is set, a request gives a one-cycle `cmd_reject` (combinational, in the request cycle). Bit 7 stays 1 and the machine stays in IDLE.
- R9: In IDLE, with no errors pending and `cmd_protected` low, a request gives `cmd_accept` in the request cycle, and bit 7 reads 0 from the next cycle on. A request in any other state gives neither `cmd_accept` nor `cmd_reject`.
- R10: `suspend_req` in PROG puts bit 2 to 1 and bit 7 to 0 for `SUSP_LAT` cycles. After that, bit 2 stays 1 and bit 7 reads 1. `resume_req` then returns to PROG and clears bit 2. `suspend_req` during an erase has no effect. `clear_flags` does not touch bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | New program or erase request this cycle |
| cmd_is_erase | input | 1 | 1 = erase request, 0 = program request |
| cmd_protected | input | 1 | Request targets a protected region |
| op_done | input | 1 | Controller finished the running operation |
| op_fail | input | 1 | Qualifies `op_done`: the operation failed to verify |
| overwrite_try | input | 1 | Program tried to turn a 0 into a 1 |
| pattern_bits | input | LEN_W | Length in bits of the pattern being programmed |
| supply_ok | input | 1 | High-voltage supply is above its threshold |
| suspend_req | input | 1 | Request to suspend the running program |
| resume_req | input | 1 | Request to resume a suspended program |
| clear_flags | input | 1 | Clear sticky error bits 5, 4 and 3 |
| cmd_accept | output | 1 | Request accepted (combinational) |
| cmd_reject | output | 1 | Request rejected (combinational) |
| flags | output | 8 | Flag byte: 7 ready, 5 erase error, 4 program error, 3 supply error, 2 suspend |

## Verification
The bench builds the block with `SUSP_LAT` = 2. This makes the suspend-pending window short enough that both of its cycles, and the move into SUSP, fall inside a few table rows. `LEN_W` keeps its default of 16, so pattern lengths of 64, 100 and 128 show both qualifying and non-qualifying overwrite attempts. The default `PATTERN_UNIT` of 64 exercises the power-of-two mask branch of the length check.

// File: rtl/flash_fsr_pkg.sv
package flash_fsr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_PROG      = 3'd1,
        ST_ERASE     = 3'd2,
        ST_SUSP_WAIT = 3'd3,
        ST_SUSP      = 3'd4
    } fsr_state_e;

    localparam int FLAG_W     = 8;
    localparam int BIT_READY  = 7;
    localparam int BIT_ERASE  = 5;
    localparam int BIT_PROG   = 4;
    localparam int BIT_SUPPLY = 3;
    localparam int BIT_SUSP   = 2;

endpackage

// File: rtl/fsr_cmd_gate.sv
module fsr_cmd_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic cmd_protected,
    input  logic engine_idle,
    input  logic err_pending,
    output logic accept,
    output logic reject
);

    logic may_decide;

    always_comb begin
        may_decide = cmd_valid && engine_idle;
        accept     = may_decide && !err_pending && !cmd_protected;
        reject     = may_decide && (err_pending || cmd_protected);
    end

    // R9
    accept_reject_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && reject));

    // R8
    pending_error_rejects_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && engine_idle && err_pending) |-> reject);

endmodule

// File: rtl/fsr_op_fsm.sv
module fsr_op_fsm
    import flash_fsr_pkg::*;
#(
    parameter int SUSP_LAT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_prog,
    input  logic start_erase,
    input  logic op_done,
    input  logic suspend_req,
    input  logic resume_req,
    output logic idle,
    output logic ready,
    output logic susp_flag,
    output logic prog_active,
    output logic erase_active
);

    localparam int CNT_W = (SUSP_LAT > 1) ? $clog2(SUSP_LAT) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SUSP_LAT - 1);

    fsr_state_e        state_q, state_d;
    logic [CNT_W-1:0]  wait_cnt_q, wait_cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            wait_cnt_q <= '0;
        end else begin
            state_q    <= state_d;
            wait_cnt_q <= wait_cnt_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        wait_cnt_d = wait_cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_prog)       state_d = ST_PROG;
                else if (start_erase) state_d = ST_ERASE;
            end
            ST_PROG: begin
                if (op_done) begin
                    state_d = ST_IDLE;
                end else if (suspend_req) begin
                    state_d    = ST_SUSP_WAIT;
                    wait_cnt_d = '0;
                end
            end
            ST_ERASE: begin
                if (op_done) state_d = ST_IDLE;
            end
            ST_SUSP_WAIT: begin
                if (op_done) begin
                    state_d = ST_IDLE;
                end else if (wait_cnt_q == CNT_LAST) begin
                    state_d = ST_SUSP;
                end else begin
                    wait_cnt_d = wait_cnt_q + 1'b1;
                end
            end
            ST_SUSP: begin
                if (resume_req) state_d = ST_PROG;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        idle         = 1'b0;
        ready        = 1'b0;
        susp_flag    = 1'b0;
        prog_active  = 1'b0;
        erase_active = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                idle  = 1'b1;
                ready = 1'b1;
            end
            ST_PROG:  prog_active  = 1'b1;
            ST_ERASE: erase_active = 1'b1;
            ST_SUSP_WAIT: begin
                prog_active = 1'b1;
                susp_flag   = 1'b1;
            end
            ST_SUSP: begin
                ready     = 1'b1;
                susp_flag = 1'b1;
            end
            default: begin
                idle  = 1'b1;
                ready = 1'b1;
            end
        endcase
    end

    // R10
    susp_wait_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SUSP_WAIT && wait_cnt_q != CNT_LAST && !op_done)
        |=> state_q == ST_SUSP_WAIT);

    // R10
    resume_to_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SUSP && resume_req) |=> state_q == ST_PROG);

    // R10
    erase_ignores_suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERASE && !op_done) |=> state_q == ST_ERASE);

endmodule

// File: rtl/fsr_flag_bank.sv
module fsr_flag_bank #(
    parameter int LEN_W        = 16,
    parameter int PATTERN_UNIT = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_start,
    input  logic             supply_ok,
    input  logic             prog_active,
    input  logic             erase_active,
    input  logic             op_done,
    input  logic             op_fail,
    input  logic             overwrite_try,
    input  logic [LEN_W-1:0] pattern_bits,
    input  logic             cmd_reject,
    input  logic             cmd_is_erase,
    input  logic             clear_flags,
    output logic             err_erase,
    output logic             err_prog,
    output logic             err_supply
);

    localparam int  UNIT_LOG = (PATTERN_UNIT > 1) ? $clog2(PATTERN_UNIT) : 1;
    localparam bit  UNIT_POW2 = ((1 << UNIT_LOG) == PATTERN_UNIT);

    logic hv_q;
    logic len_multiple;
    logic len_ok;
    logic set_erase, set_prog, set_supply;
    logic err_erase_q, err_prog_q, err_supply_q;

    generate
        if (UNIT_POW2 && UNIT_LOG < LEN_W) begin : g_mask
            assign len_multiple = (pattern_bits[UNIT_LOG-1:0] == '0);
        end else begin : g_mod
            assign len_multiple = ((pattern_bits % LEN_W'(PATTERN_UNIT)) == '0);
        end
    endgenerate

    always_comb begin
        len_ok     = len_multiple && (pattern_bits != '0);
        set_erase  = (erase_active && op_done && op_fail)
                   || (cmd_reject && cmd_is_erase);
        set_prog   = (prog_active && op_done && op_fail)
                   || (cmd_reject && !cmd_is_erase)
                   || (prog_active && overwrite_try && hv_q && len_ok);
        set_supply = (prog_active || erase_active) && hv_q && !supply_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hv_q <= 1'b0;
        end else if (op_start) begin
            hv_q <= supply_ok;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_erase_q  <= 1'b0;
            err_prog_q   <= 1'b0;
            err_supply_q <= 1'b0;
        end else begin
            err_erase_q  <= set_erase  || (err_erase_q  && !clear_flags);
            err_prog_q   <= set_prog   || (err_prog_q   && !clear_flags);
            err_supply_q <= set_supply || (err_supply_q && !clear_flags);
        end
    end

    assign err_erase  = err_erase_q;
    assign err_prog   = err_prog_q;
    assign err_supply = err_supply_q;

    // R7
    sticky_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_erase_q && !clear_flags) |=> err_erase_q);

    // R7
    sticky_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_prog_q && !clear_flags) |=> err_prog_q);

    // R6
    no_supply_without_hv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hv_q && !err_supply_q) |=> !err_supply_q);

    // R3
    erase_reject_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_reject && cmd_is_erase) |=> err_erase_q);

endmodule

// File: rtl/flash_flag_status.sv
module flash_flag_status
    import flash_fsr_pkg::*;
#(
    parameter int LEN_W        = 16,
    parameter int PATTERN_UNIT = 64,
    parameter int SUSP_LAT     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_is_erase,
    input  logic             cmd_protected,
    input  logic             op_done,
    input  logic             op_fail,
    input  logic             overwrite_try,
    input  logic [LEN_W-1:0] pattern_bits,
    input  logic             supply_ok,
    input  logic             suspend_req,
    input  logic             resume_req,
    input  logic             clear_flags,
    output logic             cmd_accept,
    output logic             cmd_reject,
    output logic [7:0]       flags
);

    logic idle, ready, susp_flag, prog_active, erase_active;
    logic err_erase, err_prog, err_supply, err_pending;
    logic start_prog, start_erase;

    assign err_pending = err_erase || err_prog || err_supply;
    assign start_prog  = cmd_accept && !cmd_is_erase;
    assign start_erase = cmd_accept && cmd_is_erase;

    fsr_cmd_gate u_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid     (cmd_valid),
        .cmd_protected (cmd_protected),
        .engine_idle   (idle),
        .err_pending   (err_pending),
        .accept        (cmd_accept),
        .reject        (cmd_reject)
    );

    fsr_op_fsm #(
        .SUSP_LAT (SUSP_LAT)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_prog   (start_prog),
        .start_erase  (start_erase),
        .op_done      (op_done),
        .suspend_req  (suspend_req),
        .resume_req   (resume_req),
        .idle         (idle),
        .ready        (ready),
        .susp_flag    (susp_flag),
        .prog_active  (prog_active),
        .erase_active (erase_active)
    );

    fsr_flag_bank #(
        .LEN_W        (LEN_W),
        .PATTERN_UNIT (PATTERN_UNIT)
    ) u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .op_start      (cmd_accept),
        .supply_ok     (supply_ok),
        .prog_active   (prog_active),
        .erase_active  (erase_active),
        .op_done       (op_done),
        .op_fail       (op_fail),
        .overwrite_try (overwrite_try),
        .pattern_bits  (pattern_bits),
        .cmd_reject    (cmd_reject),
        .cmd_is_erase  (cmd_is_erase),
        .clear_flags   (clear_flags),
        .err_erase     (err_erase),
        .err_prog      (err_prog),
        .err_supply    (err_supply)
    );

    always_comb begin
        flags             = '0;
        flags[BIT_READY]  = ready;
        flags[BIT_ERASE]  = err_erase;
        flags[BIT_PROG]   = err_prog;
        flags[BIT_SUPPLY] = err_supply;
        flags[BIT_SUSP]   = susp_flag;
    end

    // R9
    accept_goes_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_accept |=> !flags[BIT_READY]);

    // R8
    reject_stays_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reject |=> flags[BIT_READY]);

    // R4
    prog_reject_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_reject && !cmd_is_erase) |=> flags[BIT_PROG]);

endmodule

// File: tb/flash_flag_status_tb_top.sv
module flash_flag_status_tb_top;

    localparam int LEN_W    = 16;
    localparam int SUSP_LAT = 2;
    localparam int NVEC     = 36;
    localparam int VEC_W    = 10 + LEN_W + 4 + 8 + 2;

    // fields: ctl {valid, erase, prot, done, fail, overwrite, supply, suspend, resume, clear},
    //         pattern length, requirement tag, expected flags after the edge, {accept, reject}
    localparam logic [VEC_W-1:0] VEC [NVEC] = '{
        {10'b1000001000, 16'd0,   4'd9,  8'h00, 2'b10},  // R9 program accepted
        {10'b0000001000, 16'd0,   4'd2,  8'h00, 2'b00},  // R2 busy program
        {10'b0000011000, 16'd128, 4'd5,  8'h10, 2'b00},  // R5 qualified overwrite
        {10'b0001001000, 16'd0,   4'd2,  8'h90, 2'b00},  // R2 back to ready
        {10'b1000001000, 16'd0,   4'd8,  8'h90, 2'b01},  // R8 pending error rejects
        {10'b0000001001, 16'd0,   4'd7,  8'h80, 2'b00},  // R7 clear
        {10'b1100000000, 16'd0,   4'd9,  8'h00, 2'b10},  // R9 erase, supply low
        {10'b0000010000, 16'd64,  4'd6,  8'h00, 2'b00},  // R6 no supply flag without hv
        {10'b0001101000, 16'd0,   4'd3,  8'hA0, 2'b00},  // R3 erase failure
        {10'b0000001001, 16'd0,   4'd7,  8'h80, 2'b00},  // R7 clear
        {10'b1000000000, 16'd0,   4'd6,  8'h00, 2'b10},  // R6 program, supply low
        {10'b0000010000, 16'd128, 4'd5,  8'h00, 2'b00},  // R5 overwrite ignored without hv
        {10'b0001001000, 16'd0,   4'd2,  8'h80, 2'b00},  // R2
        {10'b1000001000, 16'd0,   4'd9,  8'h00, 2'b10},  // R9
        {10'b0000011000, 16'd100, 4'd5,  8'h00, 2'b00},  // R5 non-multiple length
        {10'b0000000000, 16'd0,   4'd6,  8'h08, 2'b00},  // R6 supply drop
        {10'b0001001000, 16'd0,   4'd2,  8'h88, 2'b00},  // R2
        {10'b1100001000, 16'd0,   4'd8,  8'hA8, 2'b01},  // R8 erase rejected
        {10'b1100001001, 16'd0,   4'd7,  8'hA0, 2'b01},  // R7 set wins over clear
        {10'b0000001001, 16'd0,   4'd7,  8'h80, 2'b00},  // R7
        {10'b1010001000, 16'd0,   4'd4,  8'h90, 2'b01},  // R4 protected program
        {10'b0000001001, 16'd0,   4'd7,  8'h80, 2'b00},  // R7
        {10'b1000001000, 16'd0,   4'd9,  8'h00, 2'b10},  // R9
        {10'b0000001100, 16'd0,   4'd10, 8'h04, 2'b00},  // R10 suspend pending
        {10'b0000001000, 16'd0,   4'd10, 8'h04, 2'b00},  // R10 still pending
        {10'b0000001000, 16'd0,   4'd10, 8'h84, 2'b00},  // R10 suspended
        {10'b1000001000, 16'd0,   4'd9,  8'h84, 2'b00},  // R9 request ignored while suspended
        {10'b0000001010, 16'd0,   4'd10, 8'h00, 2'b00},  // R10 resume
        {10'b0001101000, 16'd0,   4'd4,  8'h90, 2'b00},  // R4 program failure
        {10'b0000001001, 16'd0,   4'd7,  8'h80, 2'b00},  // R7
        {10'b1110001000, 16'd0,   4'd3,  8'hA0, 2'b01},  // R3 protected erase
        {10'b0000001001, 16'd0,   4'd7,  8'h80, 2'b00},  // R7
        {10'b1000001000, 16'd0,   4'd9,  8'h00, 2'b10},  // R9
        {10'b0000011001, 16'd64,  4'd7,  8'h10, 2'b00},  // R7 overwrite wins over clear
        {10'b0001001000, 16'd0,   4'd2,  8'h90, 2'b00},  // R2
        {10'b0000001001, 16'd0,   4'd7,  8'h80, 2'b00}   // R7
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0, cmd_is_erase = 1'b0, cmd_protected = 1'b0;
    logic             op_done = 1'b0, op_fail = 1'b0, overwrite_try = 1'b0;
    logic [LEN_W-1:0] pattern_bits = '0;
    logic             supply_ok = 1'b1, suspend_req = 1'b0, resume_req = 1'b0;
    logic             clear_flags = 1'b0;
    logic             cmd_accept, cmd_reject;
    logic [7:0]       flags;

    int applied = 0;
    int miscompares = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    flash_flag_status #(
        .LEN_W        (LEN_W),
        .PATTERN_UNIT (64),
        .SUSP_LAT     (SUSP_LAT)
    ) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid     (cmd_valid),
        .cmd_is_erase  (cmd_is_erase),
        .cmd_protected (cmd_protected),
        .op_done       (op_done),
        .op_fail       (op_fail),
        .overwrite_try (overwrite_try),
        .pattern_bits  (pattern_bits),
        .supply_ok     (supply_ok),
        .suspend_req   (suspend_req),
        .resume_req    (resume_req),
        .clear_flags   (clear_flags),
        .cmd_accept    (cmd_accept),
        .cmd_reject    (cmd_reject),
        .flags         (flags)
    );

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            4'd9:    return "R9";
            4'd10:   return "R10";
            default: return "R?";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        applied++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic drive_idle();
        cmd_valid = 1'b0; cmd_is_erase = 1'b0; cmd_protected = 1'b0;
        op_done = 1'b0; op_fail = 1'b0; overwrite_try = 1'b0;
        pattern_bits = '0; supply_ok = 1'b1; suspend_req = 1'b0;
        resume_req = 1'b0; clear_flags = 1'b0;
    endtask

    initial begin
        drive_idle();
        repeat (3) @(negedge clk);
        // R1 reset value
        check("R1", "flags in reset", flags, 8'h80);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "flags after reset", flags, 8'h80);

        for (int i = 0; i < NVEC; i++) begin
            logic [VEC_W-1:0] v;
            v = VEC[i];
            {cmd_valid, cmd_is_erase, cmd_protected, op_done, op_fail,
             overwrite_try, supply_ok, suspend_req, resume_req, clear_flags} = v[VEC_W-1 -: 10];
            pattern_bits = v[VEC_W-11 -: LEN_W];
            #1;
            check(tag_name(v[13:10]), "accept/reject", {6'd0, cmd_accept, cmd_reject}, {6'd0, v[1:0]});
            @(posedge clk);
            #1;
            check(tag_name(v[13:10]), "flags", flags, v[9:2]);
            @(negedge clk);
        end

        // R10 suspend during erase has no effect
        drive_idle();
        cmd_valid = 1'b1; cmd_is_erase = 1'b1;
        @(negedge clk);
        drive_idle();
        check("R2", "erase busy", flags, 8'h00);
        suspend_req = 1'b1;
        @(negedge clk);
        drive_idle();
        @(negedge clk);
        check("R10", "suspend ignored in erase", flags, 8'h00);
        // R9 request while erasing is neither accepted nor rejected
        cmd_valid = 1'b1;
        #1;
        check("R9", "request in erase", {6'd0, cmd_accept, cmd_reject}, 8'h00);
        drive_idle();
        // R1 reset in mid-operation
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "reset mid-erase", flags, 8'h80);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "idle after reset", flags, 8'h80);

        if (!done_flag) begin
            done_flag = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    end

endmodule